// File: doc/BRIEF.md
# Process-Tagged Virtual Data Cache

This block is a small direct-mapped data cache. It takes both its line index and its tag from the virtual address, so a lookup starts as soon as a CPU request arrives and does not wait for address translation. Each line also holds the process identifier of the process that filled it. When process tagging is enabled, lines that belong to several processes can stay in the cache across context switches, and none of them gives a false hit to another process.

The translation port is used only when a lookup misses. On a read miss the controller sends the virtual address and process identifier for translation. It then reads the word at the physical address it gets back and fills the line. Stores are write-through and do not allocate. A store that hits writes memory through a physical line address kept in the line, so it needs no translation. A store that misses is translated first. If translation reports a fault, the access is aborted and the CPU gets an error flag.

When process tagging is switched off by the mode input, the process identifier takes no part in the hit test. In that mode a change of the current process identifier starts an automatic invalidation of every line before the next request is taken. A flush command starts the same sweep. The sweep clears one line per cycle and holds a busy output high while it runs.

Top module: `vtc_cache`

## Requirements
- R1: A read that misses raises `xl_req` with the request's virtual address and process identifier. It then raises `mem_req` with `mem_we`=0 at the physical address that translation returned, and responds with the memory word. The line is filled.
- R2: A read that hits raises neither `xl_req` nor `mem_req`. It responds with the stored word, and `cpu_rvalid` is high in the cycle after the request is accepted.
- R3: With `pid_mode`=1, a read whose virtual address matches a valid line but whose process identifier differs from the stored one is a miss.
- R4: With `pid_mode`=0, a change of `cpu_pid` while idle starts an invalidation sweep of exactly LINES busy cycles. The next read of an address that was cached before the change misses. If the identifier does not change, a second read of the same address hits.
- R5: The cache is direct mapped, and the line index is the low log2(LINES) bits of the word-granular virtual address. Two addresses with the same index and different tags evict each other. Addresses with different indices stay resident together.
- R6: A one-cycle pulse on `flush` while idle holds `busy` high for exactly LINES cycles and invalidates every line, so a later read of a previously cached address misses.
- R7: `cpu_stall` is high from the cycle after a request that misses, or after any store, until the response cycle. It stays low for a read hit.
- R8: Stores are write-through with no allocate. A store miss is translated and written to memory at the translated address with `mem_we`=1, and the line is not filled. A store hit writes memory at the line's stored physical address without translation and updates the cached word.
- R9: A translation response with `xl_fault`=1 ends the access with `cpu_err`=1. No memory access is made, and the line at that index is left unchanged.
- R10: After reset the block is idle, with `busy`, `cpu_stall`, `cpu_rvalid`, `xl_req` and `mem_req` all low. Every response holds `cpu_rvalid` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_mode | input | 1 | 1: process identifier takes part in the hit test; 0: identifier change forces invalidation |
| flush | input | 1 | Invalidate-all command, accepted while idle |
| busy | output | 1 | Invalidation sweep in progress |
| cpu_req | input | 1 | Request, accepted while idle |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_va | input | VA_W | Word-granular virtual address |
| cpu_pid | input | PID_W | Current process identifier |
| cpu_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Miss or store being serviced |
| cpu_rvalid | output | 1 | One-cycle response strobe |
| cpu_rdata | output | DATA_W | Load data |
| cpu_err | output | 1 | Translation fault on this access |
| xl_req | output | 1 | Translation request |
| xl_va | output | VA_W | Virtual address to translate |
| xl_pid | output | PID_W | Process identifier to translate under |
| xl_ack | input | 1 | Translation response valid |
| xl_fault | input | 1 | Translation failed |
| xl_pa | input | PA_W | Translated physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_pa | output | PA_W | Physical word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | DATA_W | Read data |

## Verification
The hardest case to reach from the ports is a store hit. It must go straight to memory through the physical address saved in the line, without touching the translation port. The stimulus first fills the line with a read miss, then issues a store to the same address and process. It checks that the translation count does not change and that the memory write carries the earlier translated address. The fault case is set up the same way: a fault is injected at an index whose line is already valid, and a later read of the original address must still hit with the same data.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XLATE = 3'd1,
    ST_MEM   = 3'd2,
    ST_RESP  = 3'd3,
    ST_SWEEP = 3'd4
  } vtc_state_e;
endpackage

// File: rtl/vtc_lines.sv
module vtc_lines #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int PID_W  = 4,
  parameter int PA_W   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PID_W-1:0]  rd_pid,
  output logic [PA_W-1:0]   rd_pa,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              fill_en,
  input  logic              data_en,
  input  logic              clr_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [DATA_W-1:0] wr_data
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [PID_W-1:0]  pid_q  [LINES];
  logic [PA_W-1:0]   pa_q   [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)                valid_q[i] <= 1'b0;
      else if (clr_en && sel)    valid_q[i] <= 1'b0;
      else if (fill_en && sel)   valid_q[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (fill_en && sel) begin
        tag_q[i] <= fill_tag;
        pid_q[i] <= fill_pid;
        pa_q[i]  <= fill_pa;
      end
      if ((fill_en || data_en) && sel) data_q[i] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_pid   = pid_q[rd_idx];
  assign rd_pa    = pa_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  always_comb begin
    assert_single_writer_R8: assert (!(fill_en && (data_en || clr_en)));
  end
endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int VA_W   = 16,
  parameter int PA_W   = 16,
  parameter int PID_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = VA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pid_mode,
  input  logic              flush,
  output logic              busy,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [VA_W-1:0]   cpu_va,
  input  logic [PID_W-1:0]  cpu_pid,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_err,
  output logic              xl_req,
  output logic [VA_W-1:0]   xl_va,
  output logic [PID_W-1:0]  xl_pid,
  input  logic              xl_ack,
  input  logic              xl_fault,
  input  logic [PA_W-1:0]   xl_pa,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_pa,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [PA_W-1:0]   lk_pa,
  input  logic [DATA_W-1:0] lk_data,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              fill_en,
  output logic              data_en,
  output logic              clr_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [PID_W-1:0]  fill_pid,
  output logic [PA_W-1:0]   fill_pa,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va);
    return va[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1:IDX_W];
  endfunction

  function automatic logic line_hit(input logic v, input logic [TAG_W-1:0] st,
                                    input logic [PID_W-1:0] sp, input logic [TAG_W-1:0] t,
                                    input logic [PID_W-1:0] p, input logic use_pid);
    return v && (st == t) && (!use_pid || (sp == p));
  endfunction

  vtc_state_e        state;
  logic [VA_W-1:0]   r_va;
  logic [PID_W-1:0]  r_pid;
  logic              r_we;
  logic [DATA_W-1:0] r_wdata;
  logic              r_hit;
  logic [PA_W-1:0]   r_pa;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_err;
  logic [IDX_W-1:0]  sweep_idx;
  logic [PID_W-1:0]  last_pid;

  // named internal events
  logic lookup_hit, pid_switch, sweep_start, accept, xl_fault_ev;
  assign lookup_hit  = line_hit(lk_valid, lk_tag, lk_pid, va_tag(cpu_va), cpu_pid, pid_mode);
  assign pid_switch  = !pid_mode && (cpu_pid != last_pid);
  assign sweep_start = (state == ST_IDLE) && (flush || pid_switch);
  assign accept      = (state == ST_IDLE) && !sweep_start && cpu_req;
  assign xl_fault_ev = (state == ST_XLATE) && xl_ack && xl_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_va      <= '0;
      r_pid     <= '0;
      r_we      <= 1'b0;
      r_wdata   <= '0;
      r_hit     <= 1'b0;
      r_pa      <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      sweep_idx <= '0;
      last_pid  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          last_pid <= cpu_pid;
          if (sweep_start) begin
            sweep_idx <= '0;
            state     <= ST_SWEEP;
          end else if (accept) begin
            r_va     <= cpu_va;
            r_pid    <= cpu_pid;
            r_we     <= cpu_we;
            r_wdata  <= cpu_wdata;
            r_hit    <= lookup_hit;
            r_pa     <= lk_pa;
            rsp_data <= lk_data;
            rsp_err  <= 1'b0;
            if (!lookup_hit)  state <= ST_XLATE;
            else if (cpu_we)  state <= ST_MEM;
            else              state <= ST_RESP;
          end
        end
        ST_XLATE: if (xl_ack) begin
          if (xl_fault) begin
            rsp_err  <= 1'b1;
            rsp_data <= '0;
            state    <= ST_RESP;
          end else begin
            r_pa  <= xl_pa;
            state <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack) begin
          if (!r_we) rsp_data <= mem_rdata;
          state <= ST_RESP;
        end
        ST_RESP: state <= ST_IDLE;
        ST_SWEEP: begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state == ST_SWEEP);
  assign cpu_stall  = (state == ST_XLATE) || (state == ST_MEM);
  assign cpu_rvalid = (state == ST_RESP);
  assign cpu_rdata  = rsp_data;
  assign cpu_err    = rsp_err;
  assign xl_req     = (state == ST_XLATE);
  assign xl_va      = r_va;
  assign xl_pid     = r_pid;
  assign mem_req    = (state == ST_MEM);
  assign mem_we     = r_we;
  assign mem_pa     = r_pa;
  assign mem_wdata  = r_wdata;

  assign rd_idx   = va_index(cpu_va);
  assign wr_idx   = busy ? sweep_idx : va_index(r_va);
  assign clr_en   = busy;
  assign fill_en  = (state == ST_MEM) && mem_ack && !r_we;
  assign data_en  = (state == ST_MEM) && mem_ack && r_we && r_hit;
  assign fill_tag = va_tag(r_va);
  assign fill_pid = r_pid;
  assign fill_pa  = r_pa;
  assign wr_data  = r_we ? r_wdata : mem_rdata;

  // assertions next to the logic they guard
  assert_no_xlate_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |-> !r_hit);
  assert_read_hit_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lookup_hit && !cpu_we) |=> (cpu_rvalid && !xl_req && !mem_req));
  assert_auto_sweep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !pid_mode && (cpu_pid != last_pid)) |=> busy);
  assert_sweep_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sweep_idx == LAST_IDX)) |=> !busy);
  assert_fault_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_ev |=> (cpu_rvalid && cpu_err && !mem_req));
  assert_one_cycle_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |=> !cpu_rvalid);
  assert_stall_not_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> cpu_rvalid);
endmodule

// File: rtl/vtc_cache.sv
module vtc_cache #(
  parameter int LINES  = 8,
  parameter int VA_W   = 16,
  parameter int PA_W   = 16,
  parameter int PID_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pid_mode,
  input  logic              flush,
  output logic              busy,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [VA_W-1:0]   cpu_va,
  input  logic [PID_W-1:0]  cpu_pid,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_err,
  output logic              xl_req,
  output logic [VA_W-1:0]   xl_va,
  output logic [PID_W-1:0]  xl_pid,
  input  logic              xl_ack,
  input  logic              xl_fault,
  input  logic [PA_W-1:0]   xl_pa,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_pa,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = VA_W - IDX_W;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              lk_valid, fill_en, data_en, clr_en;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [PID_W-1:0]  lk_pid, fill_pid;
  logic [PA_W-1:0]   lk_pa, fill_pa;
  logic [DATA_W-1:0] lk_data, wr_data;

  vtc_lines #(.LINES(LINES), .TAG_W(TAG_W), .PID_W(PID_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(lk_valid), .rd_tag(lk_tag), .rd_pid(lk_pid),
    .rd_pa(lk_pa), .rd_data(lk_data),
    .wr_idx(wr_idx), .fill_en(fill_en), .data_en(data_en), .clr_en(clr_en),
    .fill_tag(fill_tag), .fill_pid(fill_pid), .fill_pa(fill_pa), .wr_data(wr_data)
  );

  vtc_ctrl #(.LINES(LINES), .VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pid_mode(pid_mode), .flush(flush), .busy(busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_va(cpu_va), .cpu_pid(cpu_pid),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
    .xl_req(xl_req), .xl_va(xl_va), .xl_pid(xl_pid), .xl_ack(xl_ack),
    .xl_fault(xl_fault), .xl_pa(xl_pa),
    .mem_req(mem_req), .mem_we(mem_we), .mem_pa(mem_pa), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_pid(lk_pid),
    .lk_pa(lk_pa), .lk_data(lk_data),
    .wr_idx(wr_idx), .fill_en(fill_en), .data_en(data_en), .clr_en(clr_en),
    .fill_tag(fill_tag), .fill_pid(fill_pid), .fill_pa(fill_pa), .wr_data(wr_data)
  );
endmodule

// File: tb/vtc_cache_test.sv
`timescale 1ns/1ps
module vtc_cache_test;
  localparam int LINES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pid_mode = 1'b1, flush = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_va = '0;
  logic [3:0]  cpu_pid = '0;
  logic [31:0] cpu_wdata = '0;
  logic busy, cpu_stall, cpu_rvalid, cpu_err, xl_req, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_wdata;
  logic [15:0] xl_va, mem_pa;
  logic [3:0]  xl_pid;
  logic xl_ack = 1'b0, xl_fault = 1'b0, mem_ack = 1'b0;
  logic [15:0] xl_pa = '0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int xl_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [15:0] last_rd_pa, last_wr_pa;
  logic [31:0] last_wr_data;
  bit done = 0;

  always #5 clk = ~clk;

  vtc_cache uut (
    .clk(clk), .rst_n(rst_n), .pid_mode(pid_mode), .flush(flush), .busy(busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_va(cpu_va), .cpu_pid(cpu_pid),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
    .xl_req(xl_req), .xl_va(xl_va), .xl_pid(xl_pid), .xl_ack(xl_ack),
    .xl_fault(xl_fault), .xl_pa(xl_pa),
    .mem_req(mem_req), .mem_we(mem_we), .mem_pa(mem_pa), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // translation model: upper nibble of F faults, otherwise pid folded into top bits
  function automatic logic [15:0] model_pa(input logic [15:0] va, input logic [3:0] pid);
    return {va[15:12] ^ pid, va[11:0]};
  endfunction
  function automatic logic [31:0] model_word(input logic [15:0] pa);
    return {~pa, pa};
  endfunction

  always @(negedge clk) begin
    xl_ack = 1'b0;
    mem_ack = 1'b0;
    if (xl_req && !xl_ack) begin
      xl_ack   = 1'b1;
      xl_fault = (xl_va[15:12] == 4'hF);
      xl_pa    = model_pa(xl_va, xl_pid);
      xl_cnt++;
    end
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        wr_cnt++;
        last_wr_pa = mem_pa;
        last_wr_data = mem_wdata;
      end else begin
        rd_cnt++;
        last_rd_pa = mem_pa;
        mem_rdata = model_word(mem_pa);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] va, input logic [3:0] pid,
                        input logic [31:0] wd, input bit exp_fast, input string req,
                        output logic [31:0] rd, output logic err);
    cpu_pid = pid;
    @(negedge clk);
    while (busy || cpu_stall || cpu_rvalid) @(negedge clk);
    cpu_we = we; cpu_va = va; cpu_wdata = wd; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    // R7: stall in the cycle after accept unless a read hit
    check(cpu_stall == !exp_fast, {req, "/R7 stall"}, 32'(cpu_stall), 32'(!exp_fast));
    if (exp_fast) check(cpu_rvalid, {req, "/R2 fast rvalid"}, 32'(cpu_rvalid), 1);
    for (int i = 0; i < 40 && !cpu_rvalid; i++) @(negedge clk);
    rd = cpu_rdata; err = cpu_err;
    @(negedge clk);
    check(!cpu_rvalid, {req, "/R10 one-cycle rvalid"}, 32'(cpu_rvalid), 0);
  endtask

  task automatic t_reset;
    check(!busy && !cpu_stall && !cpu_rvalid && !xl_req && !mem_req, "R10 reset idle",
          {27'd0, busy, cpu_stall, cpu_rvalid, xl_req, mem_req}, 0);
  endtask

  task automatic t_miss_hit;
    logic [31:0] d; logic e; int x0, r0;
    x0 = xl_cnt; r0 = rd_cnt;
    access(0, 16'h0012, 4'd1, 0, 0, "R1", d, e);
    check(xl_cnt == x0 + 1 && rd_cnt == r0 + 1, "R1 xlate+read", xl_cnt - x0, 1);
    check(last_rd_pa == model_pa(16'h0012, 1), "R1 read pa", last_rd_pa, model_pa(16'h0012, 1));
    check(d == model_word(model_pa(16'h0012, 1)) && !e, "R1 data", d, model_word(model_pa(16'h0012, 1)));
    x0 = xl_cnt; r0 = rd_cnt;
    access(0, 16'h0012, 4'd1, 0, 1, "R2", d, e);
    check(xl_cnt == x0 && rd_cnt == r0, "R2 no xlate/mem on hit", xl_cnt - x0 + rd_cnt - r0, 0);
    check(d == model_word(model_pa(16'h0012, 1)), "R2 hit data", d, model_word(model_pa(16'h0012, 1)));
  endtask

  task automatic t_pid;
    logic [31:0] d; logic e; int x0;
    pid_mode = 1'b1;
    x0 = xl_cnt;
    access(0, 16'h0012, 4'd2, 0, 0, "R3", d, e);
    check(xl_cnt == x0 + 1, "R3 other pid misses", xl_cnt - x0, 1);
    check(d == model_word(model_pa(16'h0012, 2)), "R3 data", d, model_word(model_pa(16'h0012, 2)));
    check(!busy, "R3 no sweep on pid change", 32'(busy), 0);
    access(0, 16'h0012, 4'd2, 0, 1, "R3 rehit", d, e);
  endtask

  task automatic t_direct;
    logic [31:0] d; logic e;
    access(0, 16'h0025, 4'd1, 0, 0, "R5 a", d, e);
    access(0, 16'h0026, 4'd1, 0, 0, "R5 b", d, e);
    access(0, 16'h0025, 4'd1, 0, 1, "R5 a hit", d, e);
    access(0, 16'h0035, 4'd1, 0, 0, "R5 conflict", d, e);
    access(0, 16'h0026, 4'd1, 0, 1, "R5 b kept", d, e);
    access(0, 16'h0025, 4'd1, 0, 0, "R5 a evicted", d, e);
    check(d == model_word(model_pa(16'h0025, 1)), "R5 data", d, model_word(model_pa(16'h0025, 1)));
  endtask

  task automatic t_write;
    logic [31:0] d; logic e; int x0, w0;
    x0 = xl_cnt; w0 = wr_cnt;
    access(1, 16'h0040, 4'd1, 32'hAAAA5555, 0, "R8 store miss", d, e);
    check(xl_cnt == x0 + 1 && wr_cnt == w0 + 1, "R8 miss xlate+write", xl_cnt - x0, 1);
    check(last_wr_pa == model_pa(16'h0040, 1) && last_wr_data == 32'hAAAA5555, "R8 write pa/data",
          last_wr_data, 32'hAAAA5555);
    access(0, 16'h0040, 4'd1, 0, 0, "R8 no allocate", d, e);
    x0 = xl_cnt; w0 = wr_cnt;
    access(1, 16'h0040, 4'd1, 32'h12345678, 0, "R8 store hit", d, e);
    check(xl_cnt == x0 && wr_cnt == w0 + 1, "R8 hit no xlate", xl_cnt - x0, 0);
    check(last_wr_pa == model_pa(16'h0040, 1), "R8 hit stored pa", last_wr_pa, model_pa(16'h0040, 1));
    access(0, 16'h0040, 4'd1, 0, 1, "R8 updated", d, e);
    check(d == 32'h12345678, "R8 updated data", d, 32'h12345678);
  endtask

  task automatic t_fault;
    logic [31:0] d; logic e; int r0, w0;
    access(0, 16'h0013, 4'd1, 0, 0, "R9 prefill", d, e);
    r0 = rd_cnt; w0 = wr_cnt;
    access(0, 16'hF003, 4'd1, 0, 0, "R9 fault", d, e);
    check(e == 1'b1, "R9 err flag", 32'(e), 1);
    check(rd_cnt == r0 && wr_cnt == w0, "R9 no mem access", rd_cnt - r0 + wr_cnt - w0, 0);
    access(1, 16'hF003, 4'd1, 32'h0BAD0BAD, 0, "R9 store fault", d, e);
    check(e == 1'b1 && wr_cnt == w0, "R9 store aborted", wr_cnt - w0, 0);
    access(0, 16'h0013, 4'd1, 0, 1, "R9 line intact", d, e);
    check(d == model_word(model_pa(16'h0013, 1)) && !e, "R9 line data", d, model_word(model_pa(16'h0013, 1)));
  endtask

  task automatic count_busy(input string req);
    int n = 0;
    for (int i = 0; i < 3 * LINES && (n == 0 || busy); i++) begin
      if (busy) n++;
      @(negedge clk);
    end
    check(n == LINES, req, n, LINES);
  endtask

  task automatic t_flush;
    logic [31:0] d; logic e;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    count_busy("R6 busy length");
    access(0, 16'h0013, 4'd1, 0, 0, "R6 flushed miss", d, e);
  endtask

  task automatic t_mode_off;
    logic [31:0] d; logic e;
    pid_mode = 1'b0;
    access(0, 16'h0050, 4'd1, 0, 0, "R4 fill", d, e);
    access(0, 16'h0050, 4'd1, 0, 1, "R4 same pid hit", d, e);
    cpu_pid = 4'd3;
    @(negedge clk);
    count_busy("R4 auto sweep length");
    access(0, 16'h0050, 4'd3, 0, 0, "R4 miss after switch", d, e);
    check(d == model_word(model_pa(16'h0050, 3)), "R4 data", d, model_word(model_pa(16'h0050, 3)));
    pid_mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_pid();
    t_direct();
    t_write();
    t_fault();
    t_flush();
    t_mode_off();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule